// File: doc/BRIEF.md
# Burst SRAM Address Load Counter

This block is the address front end of a synchronous burst memory. On a rising clock edge it captures a 15-bit word address when one of two active-low load strobes is asserted and the select conditions for that strobe are met. It then walks through a four-word burst. Each edge on which the active-low advance input is low moves the burst on by one beat. The current word address is presented on the output for the memory array behind it.

There are two load strobes. The controller-side strobe ignores the chip-enable input and needs only the two secondary selects. The processor-side strobe needs the full chip select: enable low, the high-active select high and the low-active select low. The burst touches only the two least significant address bits, and the upper bits keep their loaded value. A static mode pin picks the order of the low bits. Interleaved order XORs the loaded low bits with the beat count. Linear order adds the beat count to the loaded low bits modulo four.

The mode pin feeds the output mux as a level and does not pass through a register. All other inputs are sampled on the rising clock edge. The block has no data path, so every pin is a plain control or address signal with no handshake.

Top module: `burst_addr_frontend`

## Requirements
- R1: While rst_n is low at a rising edge, the stored base address and the beat count clear, so word_addr reads 0 after that edge.
- R2: When ld_ctl_n is low, sel_hi is high and sel_lo_n is low at a rising edge, addr_in is loaded whatever ce_n is. word_addr equals addr_in after that edge.
- R3: When ld_cpu_n is low, ce_n is low, sel_hi is high and sel_lo_n is low at a rising edge, addr_in is loaded and word_addr equals it after that edge.
- R4: ld_cpu_n low with ce_n high, and ld_ctl_n high, loads nothing. word_addr is unchanged.
- R5: With sel_hi low or sel_lo_n high, neither strobe loads and word_addr is unchanged.
- R6: With no load, adv_n low at a rising edge advances the beat count by one. adv_n high holds word_addr.
- R7: With order_il = 0 (linear), word_addr[1:0] equals the loaded low bits plus the beat count, modulo 4.
- R8: With order_il = 1 (interleaved), word_addr[1:0] equals the loaded low bits XOR the beat count.
- R9: Advancing never changes word_addr[14:2]. The burst wraps within its four-word group.
- R10: A load in the same cycle as adv_n low wins. word_addr equals addr_in exactly and the beat count restarts at 0.
- R11: order_il acts as a level. Changing it between clock edges changes word_addr[1:0] without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | 15 | Word address to load |
| ld_ctl_n | input | 1 | Controller-side load strobe, active low, not gated by ce_n |
| ld_cpu_n | input | 1 | Processor-side load strobe, active low, gated by ce_n |
| ce_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear (static level) |
| word_addr | output | 15 | Current memory word address |

## Verification
Each load strobe is tried with every select combination that separates them. A controller load with ce_n high must succeed and a processor load with ce_n high must fail, which shows the two gating rules are really different. Linear and interleaved bursts start from non-zero low bits so that addition and XOR give different sequences, and a full four-beat walk shows the wrap and that the upper bits stay fixed. A load that coincides with advance, and a mode toggle between edges, separate load priority from counting and a combinational order mux from a registered one.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_LOAD    = 2'd1,
    ACT_ADVANCE = 2'd2
  } burst_act_e;
endpackage

// File: rtl/burst_load_decode.sv
module burst_load_decode
  import burst_pkg::*;
(
  input  logic       ld_ctl_n,
  input  logic       ld_cpu_n,
  input  logic       ce_n,
  input  logic       sel_hi,
  input  logic       sel_lo_n,
  input  logic       adv_n,
  output burst_act_e act
);
  logic side_sel;
  logic ctl_hit;
  logic cpu_hit;

  always_comb begin
    side_sel = sel_hi & ~sel_lo_n;
    ctl_hit  = ~ld_ctl_n & side_sel;
    cpu_hit  = ~ld_cpu_n & ~ce_n & side_sel;
    if (ctl_hit || cpu_hit)
      act = ACT_LOAD;
    else if (!adv_n)
      act = ACT_ADVANCE;
    else
      act = ACT_HOLD;
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_act_e        act,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [BURST_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          base_q <= addr_in;
          beat_q <= '0;
        end
        ACT_ADVANCE: beat_q <= beat_q + 1'b1;
        default: begin
          base_q <= base_q;
          beat_q <= beat_q;
        end
      endcase
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input  logic [ADDR_W-1:0]  base_q,
  input  logic [BURST_W-1:0] beat_q,
  input  burst_order_e       order,
  output logic [ADDR_W-1:0]  word_addr
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [BURST_W-1:0] low_lin;
  logic [BURST_W-1:0] low_il;
  logic [BURST_W-1:0] low_sel;

  assign low_lin = base_q[BURST_W-1:0] + beat_q;

  genvar gb;
  generate
    for (gb = 0; gb < BURST_W; gb++) begin : g_il_bit
      assign low_il[gb] = base_q[gb] ^ beat_q[gb];
    end
  endgenerate

  always_comb begin
    low_sel = (order == ORD_INTERLEAVE) ? low_il : low_lin;
  end

  assign word_addr = {base_q[ADDR_W-1 -: UPPER_W], low_sel};
endmodule

// File: rtl/burst_addr_frontend.sv
module burst_addr_frontend
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ld_ctl_n,
  input  logic              ld_cpu_n,
  input  logic              ce_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              adv_n,
  input  logic              order_il,
  output logic [ADDR_W-1:0] word_addr
);
  burst_act_e         act;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  burst_order_e       order;

  assign order = burst_order_e'(order_il);

  burst_load_decode u_dec (
    .ld_ctl_n (ld_ctl_n),
    .ld_cpu_n (ld_cpu_n),
    .ce_n     (ce_n),
    .sel_hi   (sel_hi),
    .sel_lo_n (sel_lo_n),
    .adv_n    (adv_n),
    .act      (act)
  );

  burst_beat_counter #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .addr_in (addr_in),
    .base_q  (base_q),
    .beat_q  (beat_q)
  );

  burst_order_map #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_map (
    .base_q    (base_q),
    .beat_q    (beat_q),
    .order     (order),
    .word_addr (word_addr)
  );
endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              ld_ctl_n,
  input logic              ld_cpu_n,
  input logic              ce_n,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic              adv_n,
  input logic              order_il,
  input logic [ADDR_W-1:0] word_addr
);
  logic no_load;
  assign no_load = !((!ld_ctl_n || (!ld_cpu_n && !ce_n)) && sel_hi && !sel_lo_n);

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ctl_n && sel_hi && !sel_lo_n) |=> (word_addr == $past(addr_in))); // R2

  AST_CPU_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctl_n && !ld_cpu_n && ce_n && adv_n && $stable(order_il)) |=> $stable(word_addr)); // R4

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    no_load |=> (word_addr[ADDR_W-1:BURST_W] == $past(word_addr[ADDR_W-1:BURST_W]))); // R9

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && !adv_n && !order_il) |=>
      (order_il || (word_addr[BURST_W-1:0] == BURST_W'($past(word_addr[BURST_W-1:0]) + 1'b1)))); // R7
endmodule

bind burst_addr_frontend burst_addr_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_in   (addr_in),
  .ld_ctl_n  (ld_ctl_n),
  .ld_cpu_n  (ld_cpu_n),
  .ce_n      (ce_n),
  .sel_hi    (sel_hi),
  .sel_lo_n  (sel_lo_n),
  .adv_n     (adv_n),
  .order_il  (order_il),
  .word_addr (word_addr)
);

// File: tb/test_burst_addr_frontend.sv
`timescale 1ns/1ps
module test_burst_addr_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] addr_in = '0;
  logic        ld_ctl_n = 1'b1;
  logic        ld_cpu_n = 1'b1;
  logic        ce_n = 1'b1;
  logic        sel_hi = 1'b1;
  logic        sel_lo_n = 1'b0;
  logic        adv_n = 1'b1;
  logic        order_il = 1'b0;
  logic [14:0] word_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_frontend i_burst_addr_frontend (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ld_ctl_n(ld_ctl_n),
    .ld_cpu_n(ld_cpu_n), .ce_n(ce_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .adv_n(adv_n), .order_il(order_il), .word_addr(word_addr)
  );

  task automatic check(input string req, input logic [14:0] exp);
    checks++;
    if (word_addr !== exp) begin
      errors++;
      $display("FAIL %s: word_addr=%h expected=%h", req, word_addr, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    ld_ctl_n = 1'b1;
    ld_cpu_n = 1'b1;
    adv_n    = 1'b1;
  endtask

  task automatic load_ctl(input logic [14:0] a);
    addr_in = a; ld_ctl_n = 1'b0; tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(); tick();
    check("R1", 15'h0000);
    rst_n = 1'b1;
  endtask

  task automatic t_ctl_load();
    ce_n = 1'b1;
    load_ctl(15'h5A3D);
    check("R2", 15'h5A3D);
  endtask

  task automatic t_cpu_load();
    ce_n = 1'b0; addr_in = 15'h1236; ld_cpu_n = 1'b0; tick();
    check("R3", 15'h1236);
  endtask

  task automatic t_cpu_blocked();
    ce_n = 1'b1; addr_in = 15'h7FFF; ld_cpu_n = 1'b0; tick();
    check("R4", 15'h1236);
  endtask

  task automatic t_sel_blocked();
    ce_n = 1'b0;
    sel_hi = 1'b0; addr_in = 15'h0F0F; ld_ctl_n = 1'b0; tick();
    check("R5", 15'h1236);
    sel_hi = 1'b1; sel_lo_n = 1'b1; ld_cpu_n = 1'b0; ld_ctl_n = 1'b0; tick();
    check("R5", 15'h1236);
    sel_lo_n = 1'b0; ce_n = 1'b1;
  endtask

  task automatic t_linear();
    logic [1:0] lo;
    order_il = 1'b0;
    load_ctl(15'h0AB2);
    for (int i = 1; i <= 4; i++) begin
      adv_n = 1'b0; tick();
      lo = 2'(2'b10 + i);
      check("R7", {13'(15'h0AB2 >> 2), lo});
    end
    check("R9", 15'h0AB2);
    tick(); tick();
    check("R6", 15'h0AB2);
  endtask

  task automatic t_interleave();
    logic [1:0] lo;
    order_il = 1'b1;
    load_ctl(15'h4C01);
    for (int i = 1; i <= 4; i++) begin
      adv_n = 1'b0; tick();
      lo = 2'b01 ^ 2'(i);
      check("R8", {13'(15'h4C01 >> 2), lo});
    end
  endtask

  task automatic t_priority();
    order_il = 1'b1;
    load_ctl(15'h4C01);
    adv_n = 1'b0; tick();
    adv_n = 1'b0; addr_in = 15'h2223; ld_ctl_n = 1'b0; tick();
    check("R10", 15'h2223);
    adv_n = 1'b0; tick();
    check("R10", 15'h2222);
    check("R6", 15'h2222);
  endtask

  task automatic t_order_level();
    order_il = 1'b0;
    load_ctl(15'h0003);
    adv_n = 1'b0; tick();
    check("R11", 15'h0000);
    order_il = 1'b1; #1;
    check("R11", 15'h0002);
    order_il = 1'b0; #1;
    check("R11", 15'h0000);
  endtask

  initial begin
    #2;
    t_reset();
    t_ctl_load();
    t_cpu_load();
    t_cpu_blocked();
    t_sel_blocked();
    t_linear();
    t_interleave();
    t_priority();
    t_order_level();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule